// File: doc/BRIEF.md
# Inter-core Send Command Dispatcher

This block sits at the register port through which a processor core issues inter-core notifications. Each accepted command is a 64-bit word at a 12-bit port offset. The block turns it into exactly one 32-bit register write aimed at another core's register space. The outgoing request carries three fields:

- a 10-bit target core number;
- a 16-bit target register address;
- 32 bits of write data.

The request is held on a valid/ready handshake until the fabric takes it.

There are three kinds of command:

- **Interrupt send.** Sets one bit in the target's interrupt-set register. It also pulses a per-core interrupt-pending strobe so that the target's interrupt line can be raised.
- **Mailbox send.** Deposits a 32-bit word into one of the target's mailbox slots.
- **Arbitrary-address send.** Writes a 32-bit word to any 16-bit register address of the target.

For the mailbox and arbitrary-address sends, a 4-bit kill mask inside the command can blank out individual payload bytes. Only one request is ever outstanding. While it waits, new commands are stalled.

Top module: `ipi_send_dispatch`

## Requirements
- R1: For every kind of send, the target core on `wr_core` equals command bits 25:16.
- R2: A command at offset 0x040, of either width, is an interrupt send. It writes address 0x1008 with data equal to 1 shifted left by command bits 4:0.
- R3: An interrupt send to core c pulses `irq_pend[c]` for exactly one cycle, the first cycle its request is valid. No bit pulses when c is not below NUM_CORES, and none pulses for the other kinds of send.
- R4: A 64-bit command at offset 0x048 is a mailbox send to address 0x1020 plus (command AND 0x1C).
- R5: A 64-bit command at offset 0x158 is an arbitrary-address send to the address in command bits 15:0.
- R6: For mailbox and arbitrary-address sends, the data is command bits 63:32, with byte i (bits 8i+7:8i) forced to zero when command bit 27+i is 1.
- R7: A mailbox or arbitrary-address command with `cmd_wide` low is dropped and produces no request.
- R8: A command at any offset other than 0x040, 0x048 or 0x158 is dropped and produces no request.
- R9: A command accepted at a clock edge (`cmd_valid` and `cmd_ready` both high) produces its request from the next cycle. The request's fields stay unchanged until a cycle with `wr_ready` high retires it.
- R10: `cmd_ready` is low in every cycle a request is valid, and returns high the cycle after the retiring handshake.
- R11: After reset, `wr_valid` is low, `irq_pend` is zero and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_wide | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| cmd_offset | input | 12 | Port offset of the command write |
| cmd_data | input | 64 | Command word |
| wr_valid | output | 1 | Outgoing register write pending |
| wr_ready | input | 1 | Fabric accepts the outgoing write |
| wr_core | output | 10 | Target core number |
| wr_addr | output | 16 | Target register address |
| wr_data | output | 32 | Target write data |
| irq_pend | output | NUM_CORES | One-cycle interrupt-pending strobe per core |

## Verification
A command accepted at edge N shows its request, and any interrupt strobe, on the outputs from edge N+1. The request stays there until the first edge at which `wr_ready` is sampled high. `cmd_ready` rises one edge after that. The bench changes inputs 1 ns after a rising edge. A behavioural model updates at each rising edge from the inputs that were stable across it. Every output is compared against the model at the falling edge, so each result is checked in the exact cycle it is due. The ready input stalls at random so that the hold and stall rules are exercised.

// File: rtl/ipi_dispatch_pkg.sv
package ipi_dispatch_pkg;

    localparam int CORE_W = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 64;
    localparam int OFF_W  = 12;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_IPI  = 2'd1,
        KIND_MAIL = 2'd2,
        KIND_ANY  = 2'd3
    } send_kind_e;

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/ipi_byte_mask.sv
module ipi_byte_mask #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0] payload,
    input  logic [NBYTES-1:0]   kill,
    output logic [8*NBYTES-1:0] masked
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign masked[8*b +: 8] = kill[b] ? 8'h00 : payload[8*b +: 8];
    end
endmodule

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_dispatch_pkg::*;
#(
    parameter logic [OFF_W-1:0]  OFF_IPI   = 12'h040,
    parameter logic [OFF_W-1:0]  OFF_MAIL  = 12'h048,
    parameter logic [OFF_W-1:0]  OFF_ANY   = 12'h158,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
    parameter logic [ADDR_W-1:0] MAIL_BASE = 16'h1020
) (
    input  logic             wide,
    input  logic [OFF_W-1:0] offset,
    input  logic [CMD_W-1:0] cmd,
    output send_kind_e       kind,
    output wr_req_t          req
);
    localparam int CORE_LSB    = 16;
    localparam int VEC_W       = 5;
    localparam int MASK_LSB    = 27;
    localparam int NBYTES      = DATA_W / 8;
    localparam int PAYLOAD_LSB = CMD_W - DATA_W;
    localparam logic [VEC_W-1:0] SLOT_MASK = 5'h1C;

    logic [DATA_W-1:0] masked_payload;
    logic              unused_bits;

    assign unused_bits = ^{cmd[31], cmd[26]};

    ipi_byte_mask #(.NBYTES(NBYTES)) u_mask (
        .payload (cmd[PAYLOAD_LSB +: DATA_W]),
        .kill    (cmd[MASK_LSB +: NBYTES]),
        .masked  (masked_payload)
    );

    always_comb begin
        kind = KIND_NONE;
        if (offset == OFF_IPI)
            kind = KIND_IPI;
        else if (wide && offset == OFF_MAIL)
            kind = KIND_MAIL;
        else if (wide && offset == OFF_ANY)
            kind = KIND_ANY;
    end

    always_comb begin
        req.core = cmd[CORE_LSB +: CORE_W];
        req.data = masked_payload;
        req.addr = cmd[ADDR_W-1:0];
        unique case (kind)
            KIND_IPI: begin
                req.addr = SET_ADDR;
                req.data = DATA_W'(1) << cmd[VEC_W-1:0];
            end
            KIND_MAIL: req.addr = MAIL_BASE + ADDR_W'(cmd[VEC_W-1:0] & SLOT_MASK);
            default: ;
        endcase
    end
endmodule

// File: rtl/ipi_irq_fanout.sv
module ipi_irq_fanout
    import ipi_dispatch_pkg::*;
#(
    parameter int NUM_CORES = 16
) (
    input  logic                 fire,
    input  logic [CORE_W-1:0]    core,
    output logic [NUM_CORES-1:0] pend
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign pend[c] = fire && (core == CORE_W'(c));
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
    import ipi_dispatch_pkg::*;
#(
    parameter int NUM_CORES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_wide,
    input  logic [11:0]          cmd_offset,
    input  logic [63:0]          cmd_data,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [9:0]           wr_core,
    output logic [15:0]          wr_addr,
    output logic [31:0]          wr_data,
    output logic [NUM_CORES-1:0] irq_pend
);
    typedef struct packed {
        logic                 valid;
        wr_req_t              req;
        logic [NUM_CORES-1:0] irq;
    } state_t;

    state_t               st_d, st_q;
    send_kind_e           dec_kind;
    wr_req_t              dec_req;
    logic [NUM_CORES-1:0] dec_irq;
    logic                 accept;

    ipi_cmd_decode u_decode (
        .wide   (cmd_wide),
        .offset (cmd_offset),
        .cmd    (cmd_data),
        .kind   (dec_kind),
        .req    (dec_req)
    );

    ipi_irq_fanout #(.NUM_CORES(NUM_CORES)) u_fanout (
        .fire (dec_kind == KIND_IPI),
        .core (dec_req.core),
        .pend (dec_irq)
    );

    assign accept = cmd_valid && !st_q.valid && (dec_kind != KIND_NONE);

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        if (st_q.valid && wr_ready)
            st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.req   = dec_req;
            st_d.irq   = dec_irq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cmd_ready = !st_q.valid;
    assign wr_valid  = st_q.valid;
    assign wr_core   = st_q.req.core;
    assign wr_addr   = st_q.req.addr;
    assign wr_data   = st_q.req.data;
    assign irq_pend  = st_q.irq;
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
    parameter int NUM_CORES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 cmd_wide,
    input logic [11:0]          cmd_offset,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic [9:0]           wr_core,
    input logic [15:0]          wr_addr,
    input logic [31:0]          wr_data,
    input logic [NUM_CORES-1:0] irq_pend
);
    logic take, off_ipi, off_mail, off_any;
    assign take     = cmd_valid && cmd_ready;
    assign off_ipi  = cmd_offset == 12'h040;
    assign off_mail = cmd_offset == 12'h048;
    assign off_any  = cmd_offset == 12'h158;

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_core) && $stable(wr_addr) && $stable(wr_data));

    p_ipi_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && off_ipi |=> wr_valid && wr_addr == 16'h1008);

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cmd_ready);

    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pend));

    p_irq_first_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pend) |-> $rose(wr_valid) && wr_addr == 16'h1008 && 32'(wr_core) < NUM_CORES);

    p_narrow_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_wide && (off_mail || off_any) |=> !wr_valid);

    p_unknown_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take && !off_ipi && !off_mail && !off_any |=> !wr_valid);
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_wide   (cmd_wide),
    .cmd_offset (cmd_offset),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_core    (wr_core),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .irq_pend   (irq_pend)
);

// File: tb/ipi_send_dispatch_tb.sv
`timescale 1ns/1ps
module ipi_send_dispatch_tb;
    localparam int NC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_wide = 1'b0;
    logic [11:0] cmd_offset = '0;
    logic [63:0] cmd_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [9:0]  wr_core;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [NC-1:0] irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_on = 0;
    int ready_pct = 70;

    // reference model state
    bit          m_valid = 0;
    bit [9:0]    m_core;
    bit [15:0]   m_addr;
    bit [31:0]   m_data;
    bit [NC-1:0] m_irq = '0;
    string       m_tag = "R9";
    string       m_atag = "R2";

    always #2.5 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wide(cmd_wide), .cmd_offset(cmd_offset), .cmd_data(cmd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_core(wr_core),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_pend(irq_pend)
    );

    function automatic bit [31:0] kill_bytes(bit [63:0] d);
        bit [31:0] r = d[63:32];
        for (int i = 0; i < 4; i++)
            if (d[27+i]) r[8*i +: 8] = 8'h00;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0;
            m_irq   <= '0;
        end else begin
            bit ready_now;
            ready_now = !m_valid;
            m_irq <= '0;
            if (m_valid && wr_ready) m_valid <= 0;
            if (cmd_valid && ready_now) begin
                int c;
                c = int'(cmd_data[25:16]);
                if (cmd_offset == 12'h040) begin
                    m_valid <= 1; m_core <= cmd_data[25:16]; m_addr <= 16'h1008;
                    m_data <= 32'd1 << cmd_data[4:0]; m_atag <= "R2"; m_tag <= "R9";
                    if (c < NC) m_irq <= NC'(1) << c;
                end else if ((cmd_offset == 12'h048 || cmd_offset == 12'h158) && !cmd_wide) begin
                    m_tag <= "R7";
                end else if (cmd_offset == 12'h048) begin
                    m_valid <= 1; m_core <= cmd_data[25:16];
                    m_addr <= 16'h1020 + 16'(cmd_data[4:0] & 5'h1C);
                    m_data <= kill_bytes(cmd_data); m_atag <= "R4"; m_tag <= "R9";
                end else if (cmd_offset == 12'h158) begin
                    m_valid <= 1; m_core <= cmd_data[25:16]; m_addr <= cmd_data[15:0];
                    m_data <= kill_bytes(cmd_data); m_atag <= "R5"; m_tag <= "R9";
                end else begin
                    m_tag <= "R8";
                end
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !done) begin
            check({m_tag, " wr_valid"}, 64'(wr_valid), 64'(m_valid));
            check("R10 cmd_ready", 64'(cmd_ready), 64'(!m_valid));
            check("R3 irq_pend", 64'(irq_pend), 64'(m_irq));
            if (m_valid) begin
                check("R1 wr_core", 64'(wr_core), 64'(m_core));
                check({m_atag, " wr_addr"}, 64'(wr_addr), 64'(m_addr));
                check(m_atag == "R2" ? "R2 wr_data" : "R6 wr_data", 64'(wr_data), 64'(m_data));
            end
        end
    end

    always begin
        @(posedge clk); #1;
        wr_ready = ($urandom_range(0, 99) < ready_pct);
    end

    task automatic send(bit wide, bit [11:0] off, bit [63:0] d);
        bit acc;
        cmd_valid = 1; cmd_wide = wide; cmd_offset = off; cmd_data = d;
        do begin
            acc = cmd_ready;
            @(posedge clk); #1;
        end while (!acc);
        cmd_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 wr_valid", 64'(wr_valid), 64'd0);
        check("R11 irq_pend", 64'(irq_pend), 64'd0);
        check("R11 cmd_ready", 64'(cmd_ready), 64'd1);
        rst_n = 1;
        model_on = 1;
        @(posedge clk); #1;
        // R2 R3: interrupt sends, narrow and wide, edge vectors, in and out of range cores
        send(0, 12'h040, 64'h0000_0000_0005_0000);
        send(1, 12'h040, 64'hFFFF_FFFF_000F_001F);
        send(0, 12'h040, 64'h0000_0000_03FF_0007);
        send(1, 12'h040, 64'h0000_0000_0010_0003);
        // R4 R6: mailbox slots and byte kill masks
        send(1, 12'h048, 64'h1122_3344_0003_001C);
        send(1, 12'h048, 64'hAABB_CCDD_7809_0004);
        send(1, 12'h048, 64'hDEAD_BEEF_2802_FFE8);
        // R5: arbitrary address
        send(1, 12'h158, 64'hCAFE_F00D_0001_ABCD);
        send(1, 12'h158, 64'h1234_5678_500A_0000);
        // R7: narrow writes to wide-only offsets
        send(0, 12'h048, 64'h1111_1111_0001_0004);
        repeat (3) @(posedge clk); #1;
        send(0, 12'h158, 64'h2222_2222_0001_1234);
        repeat (3) @(posedge clk); #1;
        // R8: unknown offsets
        send(1, 12'h044, 64'h3333_3333_0002_0001);
        repeat (3) @(posedge clk); #1;
        send(1, 12'hFFF, 64'h4444_4444_0002_0001);
        repeat (3) @(posedge clk); #1;
        // R9 R10: long stall then back-to-back traffic
        ready_pct = 0;
        send(1, 12'h158, 64'h5555_AAAA_0004_0100);
        repeat (6) @(posedge clk); #1;
        ready_pct = 100;
        for (int k = 0; k < 400; k++) begin
            int sel;
            bit [11:0] off;
            sel = $urandom_range(0, 4);
            off = (sel == 0) ? 12'h040 : (sel == 1) ? 12'h048 : (sel == 2) ? 12'h158 :
                  (sel == 3) ? 12'(($urandom_range(0, 4095))) : 12'h048;
            ready_pct = (k < 200) ? 50 : 100;
            send(1'($urandom_range(0, 1)), off, {$urandom(), $urandom()});
        end
        ready_pct = 100;
        repeat (5) @(posedge clk); #1;
        finish_run();
    end
endmodule